// File: doc/BRIEF.md
# Rasterization start-tile search unit

This unit picks a first pixel position inside one screen tile that is also covered by a triangle, so that a traversal rasterizer can begin walking the primitive from a known-good seed. On a start strobe it captures three fixed-point vertex positions, three sets of edge-function coefficients and the origin of a square tile. It then tries a fixed escalation of tests, cheapest first, and stops at the first one that yields a position.

The escalation runs as follows. First, any vertex whose pixel lies in the tile is taken as the seed. Next, the rounded centroid is tried. Next, a quadrant descent steered toward the centroid is tried, one level per cycle. Last, one side of the tile boundary is scanned, one pixel per cycle. If nothing is found, the unit reports that the triangle misses the tile. Edge-function setup and the traversal itself sit outside the block.

Top module: `tile_seed_finder`

## Requirements
- R1: A start strobe is taken only when the unit is idle. A strobe raised during a search leaves that search, its captured inputs and its result unchanged.
- R2: A vertex pixel is its coordinate shifted right by FRAC (floor). The tile spans x in [tile_x, tile_x+TILE) and y in [tile_y, tile_y+TILE). The first vertex in index order 0, 1, 2 whose pixel lies in the tile becomes the seed, with found high and done in cycle 1 after the start edge.
- R3: A pixel (x,y) is covered when, for every edge k, E_k = A_k*x + B_k*y + C_k is positive. A zero value also counts when A_k > 0, or when A_k == 0 and B_k > 0.
- R4: The centroid pixel on each axis is (sum of the three fixed-point coordinates * K + 2^(15+FRAC)) >> (16+FRAC), with K = (2^16+2)/3. When no vertex hits and the centroid is in the tile and covered, it is the seed, with done in cycle 2.
- R5: Quadrant descent runs for L = log2(TILE) levels, with an offset (rx,ry) that starts at 0. At level n (0-based), half = TILE >> (n+1). The x offset moves to rx+half when centroid_x >= tile_x+rx+half, and y is handled the same way. The candidate pixel is tile origin + new offset + half/2. A covered candidate is the seed, with done in cycle 3+n.
- R6: The boundary scan takes the left column if centroid_x < tile_x, else the right column if centroid_x > tile_x+TILE-1, else the top row if centroid_y < tile_y, else the bottom row. It walks index j = 0..TILE-1 in ascending coordinate order. The first covered pixel is the seed, with done in cycle 3+L+j.
- R7: When every test fails, done rises with found low in cycle 2+L+TILE.
- R8: done is a single-cycle pulse. found and the position change only in the cycle done is high, and hold until the next result. After reset, done, found and the position are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| vx_i | input | 3*(CW+FRAC) | Vertex x coordinates, fixed point |
| vy_i | input | 3*(CW+FRAC) | Vertex y coordinates, fixed point |
| ea_i | input | 3*EW | Edge x coefficients, signed |
| eb_i | input | 3*EW | Edge y coefficients, signed |
| ec_i | input | 3*CCW | Edge constants, signed |
| tile_x_i | input | CW | Tile origin x in pixels |
| tile_y_i | input | CW | Tile origin y in pixels |
| found_o | output | 1 | A covered seed was found |
| done_o | output | 1 | Search finished (one-cycle pulse) |
| pos_x_o | output | CW | Seed x in pixels |
| pos_y_o | output | CW | Seed y in pixels |

## Verification
Triangles are chosen so that each stage of the escalation becomes the one that succeeds in turn. Each case is told apart by the seed position and the done cycle:
- a vertex inside the tile, with two vertices competing for priority and one fractional coordinate on the tile edge;
- a large triangle whose centroid lands in the tile;
- off-tile centroids that send the quadrant descent to its first and its deepest level;
- slim coverage regions reachable only through the bottom-row or left-column scan;
- a distant triangle that misses the tile.

Hand-written edge coefficients that put zero exactly on the centroid separate the two sides of the tie rule. A second start issued mid-search shows whether the busy unit ignores it.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VTX,
    ST_COG,
    ST_QUAD,
    ST_SCAN
  } tsf_state_e;
endpackage

// File: rtl/tsf_edge_eval.sv
module tsf_edge_eval #(
  parameter int EW  = 16,
  parameter int CW  = 12,
  parameter int CCW = 32,
  parameter int EVW = 34
) (
  input  logic [EW-1:0]  a_i,
  input  logic [EW-1:0]  b_i,
  input  logic [CCW-1:0] c_i,
  input  logic [CW-1:0]  x_i,
  input  logic [CW-1:0]  y_i,
  output logic           pass_o
);
  logic signed [EVW-1:0] av, bv, cv, xv, yv, val;

  always_comb begin
    av  = EVW'($signed(a_i));
    bv  = EVW'($signed(b_i));
    cv  = EVW'($signed(c_i));
    xv  = EVW'({1'b0, x_i});
    yv  = EVW'({1'b0, y_i});
    val = av * xv + bv * yv + cv;
    // zero on the edge: owned by edges facing +x, or +y when vertical-free
    pass_o = (val > 0) || ((val == 0) && ((av > 0) || ((av == 0) && (bv > 0))));
  end
endmodule

// File: rtl/tsf_centroid.sv
module tsf_centroid #(
  parameter int VW   = 16,
  parameter int CW   = 12,
  parameter int FRAC = 4,
  parameter int KB   = 16
) (
  input  logic [2:0][VW-1:0] v_i,
  output logic [CW:0]        c_o
);
  localparam int SW = VW + 2;
  localparam int PW = SW + KB;
  localparam logic [PW-1:0] K_THIRD = PW'(((1 << KB) + 2) / 3);
  localparam logic [PW-1:0] RND     = PW'(1) << (KB + FRAC - 1);

  logic [SW-1:0] sum;
  logic [PW-1:0] prod;

  always_comb begin
    sum  = SW'(v_i[0]) + SW'(v_i[1]) + SW'(v_i[2]);
    prod = PW'(sum) * K_THIRD + RND;
    c_o  = prod[KB+FRAC +: CW+1];
  end
endmodule

// File: rtl/tile_seed_finder.sv
module tile_seed_finder
  import tsf_pkg::*;
#(
  parameter int CW   = 12,
  parameter int FRAC = 4,
  parameter int EW   = 16,
  parameter int CCW  = 32,
  parameter int TILE = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [2:0][CW+FRAC-1:0]     vx_i,
  input  logic [2:0][CW+FRAC-1:0]     vy_i,
  input  logic [2:0][EW-1:0]          ea_i,
  input  logic [2:0][EW-1:0]          eb_i,
  input  logic [2:0][CCW-1:0]         ec_i,
  input  logic [CW-1:0]               tile_x_i,
  input  logic [CW-1:0]               tile_y_i,
  output logic                        found_o,
  output logic                        done_o,
  output logic [CW-1:0]               pos_x_o,
  output logic [CW-1:0]               pos_y_o
);
  localparam int VW   = CW + FRAC;
  localparam int LOGT = $clog2(TILE);
  localparam int XW   = CW + 2;
  localparam int PMAX = ((EW + CW + 1) > CCW) ? (EW + CW + 1) : CCW;
  localparam int EVW  = PMAX + 2;
  localparam logic [CW-1:0]   TM1  = CW'(TILE - 1);
  localparam logic [LOGT-1:0] LAST = LOGT'(TILE - 1);
  localparam logic [LOGT-1:0] LVLE = LOGT'(LOGT - 1);

  tsf_state_e state_q;
  logic [2:0][VW-1:0]  vx_q, vy_q;
  logic [2:0][EW-1:0]  ea_q, eb_q;
  logic [2:0][CCW-1:0] ec_q;
  logic [CW-1:0]       tx_q, ty_q;
  logic [LOGT-1:0]     rx_q, ry_q, lvl_q, idx_q;

  // vertex test
  logic [2:0] vin;
  logic [2:0][CW-1:0] vpx, vpy;
  for (genvar k = 0; k < 3; k++) begin : g_vtx
    assign vpx[k] = vx_q[k][VW-1:FRAC];
    assign vpy[k] = vy_q[k][VW-1:FRAC];
    assign vin[k] = (XW'(vpx[k]) >= XW'(tx_q)) && (XW'(vpx[k]) < XW'(tx_q) + XW'(TILE)) &&
                    (XW'(vpy[k]) >= XW'(ty_q)) && (XW'(vpy[k]) < XW'(ty_q) + XW'(TILE));
  end

  logic          vhit;
  logic [CW-1:0] vsel_x, vsel_y;
  always_comb begin
    vhit = 1'b0; vsel_x = '0; vsel_y = '0;
    for (int k = 2; k >= 0; k--) begin
      if (vin[k]) begin
        vhit = 1'b1; vsel_x = vpx[k]; vsel_y = vpy[k];
      end
    end
  end

  // centroid
  logic [CW:0] cog_x, cog_y;
  tsf_centroid #(.VW(VW), .CW(CW), .FRAC(FRAC), .KB(16)) u_cog_x (.v_i(vx_q), .c_o(cog_x));
  tsf_centroid #(.VW(VW), .CW(CW), .FRAC(FRAC), .KB(16)) u_cog_y (.v_i(vy_q), .c_o(cog_y));

  logic cog_in;
  assign cog_in = (XW'(cog_x) >= XW'(tx_q)) && (XW'(cog_x) < XW'(tx_q) + XW'(TILE)) &&
                  (XW'(cog_y) >= XW'(ty_q)) && (XW'(cog_y) < XW'(ty_q) + XW'(TILE));

  // quadrant step toward the centroid
  logic [CW-1:0] half_w, qx_off, qy_off;
  always_comb begin
    half_w = CW'(TILE) >> (32'(lvl_q) + 1);
    qx_off = (XW'(cog_x) >= XW'(tx_q) + XW'(rx_q) + XW'(half_w)) ? CW'(rx_q) + half_w : CW'(rx_q);
    qy_off = (XW'(cog_y) >= XW'(ty_q) + XW'(ry_q) + XW'(half_w)) ? CW'(ry_q) + half_w : CW'(ry_q);
  end

  // boundary side facing the centroid
  logic sd_left, sd_right, sd_top;
  logic [CW-1:0] scan_x, scan_y;
  always_comb begin
    sd_left  = XW'(cog_x) < XW'(tx_q);
    sd_right = XW'(cog_x) > XW'(tx_q) + XW'(TM1);
    sd_top   = XW'(cog_y) < XW'(ty_q);
    scan_x   = sd_left ? tx_q : sd_right ? tx_q + TM1 : tx_q + CW'(idx_q);
    scan_y   = (sd_left || sd_right) ? ty_q + CW'(idx_q) : sd_top ? ty_q : ty_q + TM1;
  end

  // candidate and shared coverage test
  logic [CW-1:0] cand_x, cand_y;
  always_comb begin
    unique case (state_q)
      ST_QUAD: begin
        cand_x = tx_q + qx_off + (half_w >> 1);
        cand_y = ty_q + qy_off + (half_w >> 1);
      end
      ST_SCAN: begin
        cand_x = scan_x;
        cand_y = scan_y;
      end
      default: begin
        cand_x = cog_x[CW-1:0];
        cand_y = cog_y[CW-1:0];
      end
    endcase
  end

  logic [2:0] epass;
  for (genvar k = 0; k < 3; k++) begin : g_edge
    tsf_edge_eval #(.EW(EW), .CW(CW), .CCW(CCW), .EVW(EVW)) u_edge (
      .a_i(ea_q[k]), .b_i(eb_q[k]), .c_i(ec_q[k]),
      .x_i(cand_x), .y_i(cand_y), .pass_o(epass[k])
    );
  end
  logic covered;
  assign covered = &epass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vx_q <= '0; vy_q <= '0; ea_q <= '0; eb_q <= '0; ec_q <= '0;
      tx_q <= '0; ty_q <= '0;
      rx_q <= '0; ry_q <= '0; lvl_q <= '0; idx_q <= '0;
      done_o <= 1'b0; found_o <= 1'b0; pos_x_o <= '0; pos_y_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          vx_q <= vx_i; vy_q <= vy_i; ea_q <= ea_i; eb_q <= eb_i; ec_q <= ec_i;
          tx_q <= tile_x_i; ty_q <= tile_y_i;
          state_q <= ST_VTX;
        end
        ST_VTX: begin
          if (vhit) begin
            done_o <= 1'b1; found_o <= 1'b1; pos_x_o <= vsel_x; pos_y_o <= vsel_y;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_COG;
          end
        end
        ST_COG: begin
          if (cog_in && covered) begin
            done_o <= 1'b1; found_o <= 1'b1; pos_x_o <= cand_x; pos_y_o <= cand_y;
            state_q <= ST_IDLE;
          end else begin
            rx_q <= '0; ry_q <= '0; lvl_q <= '0;
            state_q <= ST_QUAD;
          end
        end
        ST_QUAD: begin
          if (covered) begin
            done_o <= 1'b1; found_o <= 1'b1; pos_x_o <= cand_x; pos_y_o <= cand_y;
            state_q <= ST_IDLE;
          end else begin
            rx_q  <= qx_off[LOGT-1:0];
            ry_q  <= qy_off[LOGT-1:0];
            lvl_q <= lvl_q + 1'b1;
            if (lvl_q == LVLE) begin
              idx_q   <= '0;
              state_q <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (covered) begin
            done_o <= 1'b1; found_o <= 1'b1; pos_x_o <= cand_x; pos_y_o <= cand_y;
            state_q <= ST_IDLE;
          end else if (idx_q == LAST) begin
            done_o <= 1'b1; found_o <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: single-cycle done
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8: results move only with done
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(found_o) && $stable(pos_x_o) && $stable(pos_y_o)));
  // R1: busy start does not reload the capture
  assert_busy_ignore_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> ($stable(vx_q) && $stable(ec_q) && $stable(tx_q)));
  // R2: every reported seed is inside the captured tile
  assert_seed_in_tile_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && found_o) |-> ((XW'(pos_x_o) >= XW'(tx_q)) && (XW'(pos_x_o) < XW'(tx_q) + XW'(TILE)) &&
                             (XW'(pos_y_o) >= XW'(ty_q)) && (XW'(pos_y_o) < XW'(ty_q) + XW'(TILE))));
  // R5: a covered quadrant candidate finishes the search next cycle
  assert_quad_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUAD && covered) |=> (done_o && found_o));
  // R7: a miss is reported only from the scan
  assert_miss_from_scan_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> ($past(state_q) == ST_SCAN));
endmodule

// File: tb/tile_seed_finder_bench.sv
module tile_seed_finder_bench;
  localparam int CW = 12, FRAC = 4, EW = 16, CCW = 32, TILE = 16, L = 4;
  localparam int VW = CW + FRAC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_s = 1'b0;
  logic [2:0][VW-1:0]  vx_s, vy_s;
  logic [2:0][EW-1:0]  ea_s, eb_s;
  logic [2:0][CCW-1:0] ec_s;
  logic [CW-1:0] tx_s, ty_s;
  logic found_o, done_o;
  logic [CW-1:0] pos_x_o, pos_y_o;

  int vx[3], vy[3], ea[3], eb[3];
  longint ec[3];
  int tx = 32, ty = 48;
  int nchk = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      vx_s[k] = VW'(vx[k]); vy_s[k] = VW'(vy[k]);
      ea_s[k] = EW'(ea[k]); eb_s[k] = EW'(eb[k]); ec_s[k] = CCW'(ec[k]);
    end
    tx_s = CW'(tx); ty_s = CW'(ty);
  end

  tile_seed_finder #(.CW(CW), .FRAC(FRAC), .EW(EW), .CCW(CCW), .TILE(TILE)) u_tile_seed_finder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s),
    .vx_i(vx_s), .vy_i(vy_s), .ea_i(ea_s), .eb_i(eb_s), .ec_i(ec_s),
    .tile_x_i(tx_s), .tile_y_i(ty_s),
    .found_o(found_o), .done_o(done_o), .pos_x_o(pos_x_o), .pos_y_o(pos_y_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit in_tile(input int x, input int y);
    return x >= tx && x < tx + TILE && y >= ty && y < ty + TILE;
  endfunction

  // R3 coverage rule
  function automatic bit cov(input int x, input int y);
    bit ok = 1'b1;
    for (int k = 0; k < 3; k++) begin
      longint e = longint'(ea[k]) * x + longint'(eb[k]) * y + ec[k];
      if (!(e > 0 || (e == 0 && (ea[k] > 0 || (ea[k] == 0 && eb[k] > 0))))) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic int cog(input int a, input int b, input int c);
    longint s = longint'(a) + b + c;
    longint kk = ((64'd1 << 16) + 2) / 3;
    return int'((s * kk + (64'd1 << (15 + FRAC))) >>> (16 + FRAC));
  endfunction

  task automatic model(output bit f, output int px, output int py, output int lat);
    int cx, cy, rx, ry;
    f = 1'b0; px = 0; py = 0; lat = 2 + L + TILE;
    for (int k = 0; k < 3; k++) begin
      if (!f && in_tile(vx[k] >>> FRAC, vy[k] >>> FRAC)) begin
        f = 1'b1; px = vx[k] >>> FRAC; py = vy[k] >>> FRAC; lat = 1;
      end
    end
    if (f) return;
    cx = cog(vx[0], vx[1], vx[2]); cy = cog(vy[0], vy[1], vy[2]);
    if (in_tile(cx, cy) && cov(cx, cy)) begin
      f = 1'b1; px = cx; py = cy; lat = 2; return;
    end
    rx = 0; ry = 0;
    for (int n = 0; n < L; n++) begin
      int h = TILE >> (n + 1);
      if (cx >= tx + rx + h) rx += h;
      if (cy >= ty + ry + h) ry += h;
      if (cov(tx + rx + h / 2, ty + ry + h / 2)) begin
        f = 1'b1; px = tx + rx + h / 2; py = ty + ry + h / 2; lat = 3 + n; return;
      end
    end
    for (int j = 0; j < TILE; j++) begin
      int sx, sy;
      if (cx < tx) begin sx = tx; sy = ty + j; end
      else if (cx > tx + TILE - 1) begin sx = tx + TILE - 1; sy = ty + j; end
      else if (cy < ty) begin sx = tx + j; sy = ty; end
      else begin sx = tx + j; sy = ty + TILE - 1; end
      if (cov(sx, sy)) begin
        f = 1'b1; px = sx; py = sy; lat = 3 + L + j; return;
      end
    end
  endtask

  task automatic set_verts(input int x0, input int y0, input int x1, input int y1, input int x2, input int y2);
    vx[0] = x0; vy[0] = y0; vx[1] = x1; vy[1] = y1; vx[2] = x2; vy[2] = y2;
  endtask

  task automatic edges_from_verts();
    int px[3], py[3];
    for (int k = 0; k < 3; k++) begin px[k] = vx[k] >>> FRAC; py[k] = vy[k] >>> FRAC; end
    for (int k = 0; k < 3; k++) begin
      int j = (k + 1) % 3;
      longint e3;
      ea[k] = py[k] - py[j]; eb[k] = px[j] - px[k];
      ec[k] = longint'(px[k]) * py[j] - longint'(px[j]) * py[k];
      e3 = longint'(ea[k]) * (px[0] + px[1] + px[2]) + longint'(eb[k]) * (py[0] + py[1] + py[2]) + 3 * ec[k];
      if (e3 < 0) begin ea[k] = -ea[k]; eb[k] = -eb[k]; ec[k] = -ec[k]; end
    end
  endtask

  task automatic set_edge(input int k, input int a, input int b, input longint c);
    ea[k] = a; eb[k] = b; ec[k] = c;
  endtask

  task automatic run_case(input string req, input string name, input bit poke);
    bit ef; int ex, ey, el, lat; bit seen; logic f0; logic [CW-1:0] x0, y0;
    model(ef, ex, ey, el);
    @(negedge clk); start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    lat = 0; seen = 1'b0;
    while (!seen && lat < 200) begin
      @(negedge clk);
      if (start_s) start_s = 1'b0;
      lat++;
      if (done_o) seen = 1'b1;
      else if (poke && lat == 3) begin
        set_verts(40*16, 50*16, 0, 0, 0, 0);   // a vertex-hit job, must be dropped
        start_s = 1'b1;
      end
    end
    start_s = 1'b0;
    chk(seen, req, {name, " done seen"}, seen, 1);
    chk(lat == el, req, {name, " done cycle"}, lat, el);
    chk(found_o == ef, req, {name, " found"}, found_o, ef);
    if (ef) begin
      chk(pos_x_o == CW'(ex), req, {name, " pos_x"}, pos_x_o, ex);
      chk(pos_y_o == CW'(ey), req, {name, " pos_y"}, pos_y_o, ey);
    end
    f0 = found_o; x0 = pos_x_o; y0 = pos_y_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R8", {name, " done pulse width"}, done_o, 0);
    @(negedge clk); @(negedge clk);
    chk(found_o == f0 && pos_x_o == x0 && pos_y_o == y0, "R8", {name, " result hold"},
        {found_o, pos_x_o, pos_y_o}, {f0, x0, y0});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && found_o == 1'b0, "R8", "reset flags", {done_o, found_o}, 0);
    chk(pos_x_o == '0 && pos_y_o == '0, "R8", "reset position", {pos_x_o, pos_y_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_vertex();
    set_verts(100*16, 100*16, 40*16, 50*16, 120*16, 10*16); edges_from_verts();
    run_case("R2", "single vertex", 1'b0);
    set_verts(100*16, 100*16, 33*16, 49*16, 45*16, 60*16); edges_from_verts();
    run_case("R2", "vertex priority", 1'b0);
    set_verts(48*16, 50*16, 47*16 + 15, 50*16 + 7, 0, 200*16); edges_from_verts();
    run_case("R2", "fractional floor", 1'b0);
  endtask

  task automatic t_centroid();
    set_verts(10*16, 30*16, 70*16, 40*16, 40*16, 90*16); edges_from_verts();
    run_case("R4", "centroid hit", 1'b0);
    set_verts(10*16, 30*16, 70*16, 40*16, 40*16, 98*16);
    set_edge(0, 1, 0, -40); set_edge(1, 0, 0, 1); set_edge(2, 0, 0, 1);
    run_case("R3", "tie owned by +x edge", 1'b0);
  endtask

  task automatic t_quad();
    set_verts(0, 0, 0, 120*16, 60*16, 56*16); edges_from_verts();
    run_case("R5", "quad level 0", 1'b0);
    set_verts(0, 40*16, 10*16, 70*16, 5*16, 100*16);
    set_edge(0, -1, 0, 33); set_edge(1, 0, 1, -55); set_edge(2, 0, 0, 1);
    run_case("R5", "quad deepest level", 1'b0);
  endtask

  task automatic t_scan();
    set_verts(10*16, 30*16, 70*16, 40*16, 40*16, 98*16);
    set_edge(0, -1, 0, 40); set_edge(1, 0, 0, 1); set_edge(2, 0, 0, 1);
    run_case("R6", "tie refused, bottom scan", 1'b0);
    set_verts(0, 40*16, 10*16, 70*16, 5*16, 100*16);
    set_edge(0, -1, 0, 33); set_edge(1, 0, 1, -50); set_edge(2, 0, -1, 52);
    run_case("R6", "left column scan", 1'b0);
  endtask

  task automatic t_miss();
    set_verts(200*16, 200*16, 250*16, 200*16, 220*16, 260*16); edges_from_verts();
    run_case("R7", "triangle misses tile", 1'b0);
  endtask

  task automatic t_busy();
    set_verts(200*16, 200*16, 250*16, 200*16, 220*16, 260*16); edges_from_verts();
    run_case("R1", "start while busy", 1'b1);
  endtask

  initial begin
    wait (cyc >= 100000);
    nfail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin vx[k] = 0; vy[k] = 0; ea[k] = 0; eb[k] = 0; ec[k] = 0; end
    t_reset();
    t_vertex();
    t_centroid();
    t_quad();
    t_scan();
    t_miss();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule